// File: doc/BRIEF.md
# Lookahead Load Tracker

This block follows the memory requests of one instruction stream that are still waiting for data. It does not use a register scoreboard. Each memory instruction word instead carries a small lookahead count. The count says how many later instruction words may issue before that load's data is needed. The tracker numbers every word it accepts. When a load is accepted, it places the load in a free request slot and stores the word number at which the data becomes necessary.

The stream may issue only while `ready` is high. `ready` goes low in two cases. The first is when the next word number equals the stored need point of a slot that is still busy. The second is when every slot is busy. Completions arrive with the tag of the slot they finish, in any order. A completion releases its slot, and `ready` comes back one clock later when nothing else blocks. `alloc_tag` always shows the slot that the next memory word will take, so the issue logic can attach the tag to the outgoing request.

Top module: `lat_lookahead_tracker`

## Requirements
- R1: After reset, `ready` is 1, no slot is busy and `alloc_tag` is 0.
- R2: `alloc_tag` shows the lowest-numbered free slot, or 0 when no slot is free. An accepted memory word takes exactly that slot.
- R3: A memory word accepted with lookahead L (L = 1..7) leaves `ready` high during the next L accepted words. After the L-th of those words, `ready` is low until the slot completes.
- R4: With lookahead 0, `ready` is low in the cycle right after the memory word is accepted.
- R5: A word with `issue_is_mem` = 0 allocates no slot and its lookahead field has no effect. It advances the word count only.
- R6: Eight memory words issued back to back with lookahead 7 are all outstanding together. While all eight slots are busy, `ready` is 0.
- R7: A completion frees the slot named by `cpl_tag`, in any order. When the slot was the only thing blocking, `ready` is 1 in the cycle after the completion.
- R8: An issue while `ready` is 0 is ignored. It does not advance the word count and takes no slot.
- R9: A completion whose tag names a free slot has no effect.
- R10: When an issue and a completion arrive in the same cycle, both take effect. The new load takes the lowest slot that was free before the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction word issues this cycle |
| issue_is_mem | input | 1 | The word carries a memory request |
| issue_lookahead | input | LA_W | Words allowed before the result is needed |
| cpl_valid | input | 1 | A memory result returns this cycle |
| cpl_tag | input | log2(SLOTS) | Slot of the returning result |
| ready | output | 1 | The stream may issue the next word |
| alloc_tag | output | log2(SLOTS) | Slot the next memory word will take |

## Verification
A wrong need point or a wrong word count shows up at the ports as `ready` dropping one word too early or too late. A bench model that tracks each slot catches this in the very cycle it happens. A slot that is freed by mistake, or never freed, changes `alloc_tag` right after the faulty edge. It can also leave `ready` stuck low. The bench sweeps every pair of lookahead values and drains the slots in several orders, so each such fault is seen within a few words.

// File: rtl/lat_pkg.sv
package lat_pkg;
    // default geometry of one stream's request tracking
    localparam int unsigned LAT_SLOTS_DEF = 8;
    localparam int unsigned LAT_LA_W_DEF  = 3;
endpackage

// File: rtl/lat_free_pick.sv
module lat_free_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned TW = $clog2(N)
) (
    input  logic [N-1:0]  busy,
    output logic [TW-1:0] pick,
    output logic          any_free
);
    logic [N-1:0] free_v;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_free
            assign free_v[g] = ~busy[g];
        end
    endgenerate

    assign any_free = |free_v;

    // lowest free index wins; zero when nothing is free
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_v[i]) pick = TW'(i);
        end
    end
endmodule

// File: rtl/lat_need_match.sv
module lat_need_match #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4
) (
    input  logic [N-1:0]         busy,
    input  logic [N-1:0][CW-1:0] need,
    input  logic [CW-1:0]        wcnt,
    output logic [N-1:0]         hit,
    output logic                 any_hit
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit[g] = busy[g] && (need[g] == wcnt);
        end
    endgenerate

    assign any_hit = |hit;
endmodule

// File: rtl/lat_lookahead_tracker.sv
module lat_lookahead_tracker #(
    parameter int unsigned SLOTS = lat_pkg::LAT_SLOTS_DEF,
    parameter int unsigned LA_W  = lat_pkg::LAT_LA_W_DEF,
    localparam int unsigned TW   = $clog2(SLOTS),
    localparam int unsigned CW   = LA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            issue_is_mem,
    input  logic [LA_W-1:0] issue_lookahead,
    input  logic            cpl_valid,
    input  logic [TW-1:0]   cpl_tag,
    output logic            ready,
    output logic [TW-1:0]   alloc_tag
);
    // The word count is kept modulo 2^CW. The stream never runs past a
    // pending need point, which lies at most 2^LA_W words ahead, so a
    // modulo compare cannot alias.
    typedef struct packed {
        logic [SLOTS-1:0]         busy;
        logic [SLOTS-1:0][CW-1:0] need;
        logic [CW-1:0]            wcnt;
    } slots_t;

    slots_t sl_d, sl_q;
    logic   ready_d, ready_q;

    logic [TW-1:0] pick;
    logic          any_free;
    logic [SLOTS-1:0] hit_nx;
    logic          block_nx;
    logic          accept, mem_acc, cpl_hit;

    lat_free_pick #(.N(SLOTS), .TW(TW)) u_pick (
        .busy     (sl_q.busy),
        .pick     (pick),
        .any_free (any_free)
    );

    always_comb begin
        accept  = issue_valid && ready_q;
        mem_acc = accept && issue_is_mem && any_free;
        cpl_hit = cpl_valid && sl_q.busy[cpl_tag];
        sl_d    = sl_q;
        if (accept) sl_d.wcnt = sl_q.wcnt + CW'(1);
        if (cpl_hit) sl_d.busy[cpl_tag] = 1'b0;
        if (mem_acc) begin
            sl_d.busy[pick] = 1'b1;
            sl_d.need[pick] = sl_q.wcnt + CW'(issue_lookahead) + CW'(1);
        end
    end

    // need check on the next state so that ready is a plain register
    lat_need_match #(.N(SLOTS), .CW(CW)) u_match (
        .busy    (sl_d.busy),
        .need    (sl_d.need),
        .wcnt    (sl_d.wcnt),
        .hit     (hit_nx),
        .any_hit (block_nx)
    );

    always_comb begin
        ready_d = !(&sl_d.busy) && !block_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q    <= '0;
            ready_q <= 1'b1;
        end else begin
            sl_q    <= sl_d;
            ready_q <= ready_d;
        end
    end

    assign ready     = ready_q;
    assign alloc_tag = pick;

    // R8
    blocked_issue_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !ready_q) |=> $stable(sl_q.wcnt));

    // R4
    la_zero_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ready_q && issue_is_mem && issue_lookahead == '0) |=> !ready_q);

    // R6
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&sl_q.busy) |-> !ready_q);

    // R7
    cpl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && sl_q.busy[cpl_tag]) |=> !sl_q.busy[$past(cpl_tag)]);

    // R2
    alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ready_q && issue_is_mem) |=> sl_q.busy[$past(alloc_tag)]);
endmodule

// File: tb/lat_lookahead_tracker_tb.sv
module lat_lookahead_tracker_tb;
    localparam int SLOTS = 8;
    localparam int LA_W  = 3;
    localparam int CW    = LA_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0, issue_is_mem = 1'b0, cpl_valid = 1'b0;
    logic [LA_W-1:0] issue_lookahead = '0;
    logic [2:0] cpl_tag = '0;
    logic ready;
    logic [2:0] alloc_tag;

    int n_chk = 0, n_bad = 0;
    bit m_busy [SLOTS];
    int m_need [SLOTS];
    int m_cnt;

    always #2.5 clk = ~clk;

    lat_lookahead_tracker #(.SLOTS(SLOTS), .LA_W(LA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_is_mem(issue_is_mem),
        .issue_lookahead(issue_lookahead), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .ready(ready), .alloc_tag(alloc_tag)
    );

    function automatic int m_free();
        for (int i = 0; i < SLOTS; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic bit m_ready();
        if (m_free() < 0) return 1'b0;
        for (int i = 0; i < SLOTS; i++)
            if (m_busy[i] && m_need[i] == m_cnt) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        int f;
        f = m_free();
        check(req, ready, m_ready());
        check(req, alloc_tag, (f < 0) ? 0 : f);
    endtask

    // one clock with the given stimulus; the model advances in step
    task automatic step(string req, bit iv, bit im, int la, bit cv, int ct);
        bit acc;
        int f;
        @(negedge clk);
        issue_valid = iv; issue_is_mem = im; issue_lookahead = LA_W'(la);
        cpl_valid = cv; cpl_tag = 3'(ct);
        acc = iv && m_ready();
        f = m_free();
        @(posedge clk);
        #1;
        issue_valid = 1'b0; cpl_valid = 1'b0;
        if (cv && m_busy[ct]) m_busy[ct] = 1'b0;
        if (acc && im && f >= 0) begin
            m_busy[f] = 1'b1;
            m_need[f] = (m_cnt + la + 1) % (1 << CW);
        end
        if (acc) m_cnt = (m_cnt + 1) % (1 << CW);
        check_all(req);
    endtask

    task automatic drain(string req);
        for (int i = 0; i < SLOTS; i++)
            if (m_busy[i]) step(req, 1'b0, 1'b0, 0, 1'b1, i);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin m_busy[i] = 1'b0; m_need[i] = 0; end
        m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", ready, 1);
        check("R1", alloc_tag, 0);

        // R3 / R4: each lookahead, plain words until blocked, then R8 and R7
        for (int L = 0; L < 8; L++) begin
            step(L == 0 ? "R4" : "R3", 1'b1, 1'b1, L, 1'b0, 0);
            for (int k = 0; k < L; k++) step("R3", 1'b1, 1'b0, 5, 1'b0, 0);
            check("R3", ready, 0);
            step("R8", 1'b1, 1'b1, 3, 1'b0, 0);
            check("R8", alloc_tag, 1);
            step("R7", 1'b0, 1'b0, 0, 1'b1, 0);
            check("R7", ready, 1);
        end

        // R5: plain words with lookahead 0 block nothing and take no slot
        for (int k = 0; k < 3; k++) begin
            step("R5", 1'b1, 1'b0, 0, 1'b0, 0);
            check("R5", ready, 1);
            check("R5", alloc_tag, 0);
        end

        // R6: eight loads in flight with lookahead 7
        for (int k = 0; k < 8; k++) begin
            check("R2", alloc_tag, k);
            step("R6", 1'b1, 1'b1, 7, 1'b0, 0);
        end
        check("R6", ready, 0);
        // R9: completion for a slot that is free has no effect (none free now; after one freed)
        step("R7", 1'b0, 1'b0, 0, 1'b1, 5);
        check("R7", alloc_tag, 5);
        step("R9", 1'b0, 1'b0, 0, 1'b1, 5);
        check("R9", alloc_tag, 5);
        step("R7", 1'b0, 1'b0, 0, 1'b1, 0);
        check("R7", ready, 1);
        // R10: issue and completion together
        step("R10", 1'b1, 1'b1, 6, 1'b1, 2);
        check("R10", alloc_tag, 2);
        drain("R7");

        // near-exhaustive sweep over lookahead pairs and drain orders
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                step("R3", 1'b1, 1'b1, a, 1'b0, 0);
                step("R3", 1'b1, 1'b1, b, 1'b0, 0);
                for (int s = 0; s < 24; s++) begin
                    if (!m_busy[0] && !m_busy[1]) break;
                    if (m_ready()) step("R3", 1'b1, 1'b0, (a + s) % 8, 1'b0, 0);
                    else if (((a ^ b) & 1) != 0 && m_busy[1]) step("R7", 1'b0, 1'b0, 0, 1'b1, 1);
                    else step("R7", 1'b0, 1'b0, 0, 1'b1, m_busy[0] ? 0 : 1);
                end
                drain("R7");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule